// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a register interface and a byte-level I2C bus engine. Software loads a byte buffer and then writes one command word. That word can request any mix of four phases: an address phase that opens a transfer, a data transmit, a data receive and a closing stop. The block runs the requested phases one after another in a fixed order. For each phase it asks the bus engine for one operation and waits for the engine to finish it.

While the command runs, a transfer-state field held beside the command bits shows which phase is in progress. Outcomes are collected in sticky status bits. Software clears those bits by writing ones, and they drive a single maskable interrupt. The state field remembers whether a transfer is open. That memory lets the block tell a stop that closes a real transfer from a stray stop issued while nothing is open, and it marks the stray stop as abnormal.

The bus engine handshake works as follows. The block raises `bus_req` with an operation code and holds it until the engine pulses `bus_done`. In the same cycle as `bus_done`, the engine returns the acknowledge result, or the received byte and an error flag.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command write accepted while `busy` is low loads all 16 low bits of `cmd_reg` from `cmd_wdata`, clears every status bit to 0 and raises `busy` on the next cycle. After reset, `cmd_reg`, `sts`, `irq`, `busy` and `bus_req` are all 0.
- R2: While `busy` is high, writes to the command word and to the byte buffer are ignored.
- R3: Command bit 0 requests the address phase. This phase issues bus operation 0, which sends `byte_buf[7:0]`: bits [7:1] hold the 7-bit slave address and bit 0 holds the direction. During the phase the state field `cmd_reg[19:16]` reads 2 if a transfer was already open (state 8), and 1 otherwise.
- R4: The address phase also counts as the transmit phase. When the address phase is acknowledged, command bits 0 and 1 are both cleared, no separate send is issued, and status bit 0 (acknowledge) is set. The state field then becomes 8 (open).
- R5: If the address is not acknowledged, status bit 1 (no-acknowledge) is set. All remaining phases of that command are skipped and `busy` drops. The state field keeps 1 or 2.
- R6: Command bit 1 alone requests the transmit phase. This phase sets the state field to 3 and issues bus operation 1 with `byte_buf[7:0]`. Acknowledge sets status bit 0. No-acknowledge sets status bit 1 and then issues bus operation 4 to end the transfer. The state field returns to 8 in both cases.
- R7: Command bit 2 (receive) or bit 3 (receive-last) requests the receive phase. This phase sets the state field to 4 and issues bus operation 2. The returned byte is placed in `byte_buf[15:8]`, or 0xFF if the engine flags an error, and status bit 2 is set.
- R8: With command bit 3 set, bus operation 3 (not-acknowledge) is issued after the receive operation completes, while the state field still reads 4.
- R9: Command bit 4 requests the stop phase. If the state field is not 8, status bit 4 (abnormal) is set and no bus operation is issued. Otherwise bus operation 4 is issued with the state field at 5, and status bit 3 (normal stop) is set. In both cases the state field ends at 0.
- R10: The phases of one command run in the order address, transmit, receive, stop. When `busy` drops, command bits [4:0] are all 0.
- R11: `irq` is high exactly when some bit of `sts & irq_en` is set. A status-clear write clears only the bits given in `sts_w1c_mask`.
- R12: `bus_req` is low while idle. Once raised, it stays high with `bus_op` and `bus_wdata` unchanged until the cycle in which `bus_done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word (bits 0 address, 1 transmit, 2 receive, 3 receive-last, 4 stop) |
| buf_we | input | 1 | Byte buffer transmit-byte write strobe |
| buf_wdata | input | 8 | Address or data byte to send |
| sts_w1c_we | input | 1 | Status clear strobe |
| sts_w1c_mask | input | 5 | Status bits to clear |
| irq_en | input | 5 | Interrupt enable per status bit |
| cmd_reg | output | 20 | State field [19:16] and command bits [15:0] |
| byte_buf | output | 16 | Received byte [15:8], byte to send [7:0] |
| sts | output | 5 | Status: 0 ack, 1 no-ack, 2 receive done, 3 normal stop, 4 abnormal |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Command in progress |
| bus_req | output | 1 | Request to bus engine |
| bus_op | output | 3 | Operation: 0 start, 1 send, 2 receive, 3 not-acknowledge, 4 stop |
| bus_wdata | output | 8 | Byte for start or send |
| bus_done | input | 1 | Engine finished the request |
| bus_nak | input | 1 | Address or data not acknowledged |
| bus_rdata | input | 8 | Received byte |
| bus_err | input | 1 | Receive failed |

## Verification
The bench targets a stop issued after an unacknowledged address, where the state field still reads 1. A design that tested the bus instead of the tracked state would report a normal stop there, or would send a stop operation. It also runs a chained command in which the address acknowledge must consume the transmit bit. A design that missed this would issue a stray send. A second address while a transfer is open must read as state 2, and a transmit no-acknowledge must be followed by an end-transfer operation; a wrong design would show state 1 or skip that operation. The bench also writes the command and buffer during a running command. A design that accepted those writes would issue a stop or send the wrong byte.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int CMD_W   = 16;
    localparam int STATE_W = 4;
    localparam int BYTE_W  = 8;
    localparam int STS_W   = 5;

    // command request bit positions
    localparam int C_ADDR  = 0;
    localparam int C_TX    = 1;
    localparam int C_RX    = 2;
    localparam int C_RXL   = 3;
    localparam int C_STOP  = 4;

    // status bit positions
    localparam int S_ACK   = 0;
    localparam int S_NAK   = 1;
    localparam int S_RXD   = 2;
    localparam int S_OK    = 3;
    localparam int S_BAD   = 4;

    typedef enum logic [STATE_W-1:0] {
        XS_IDLE   = 4'd0,
        XS_START  = 4'd1,
        XS_RSTART = 4'd2,
        XS_TXD    = 4'd3,
        XS_RXD    = 4'd4,
        XS_STOP   = 4'd5,
        XS_OPEN   = 4'd8
    } xfer_state_e;

    typedef enum logic [2:0] {
        OP_START = 3'd0,
        OP_SEND  = 3'd1,
        OP_RECV  = 3'd2,
        OP_NACK  = 3'd3,
        OP_STOP  = 3'd4
    } bus_op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PICK,
        PH_ADDR,
        PH_TX,
        PH_TXEND,
        PH_RX,
        PH_NACK,
        PH_STOP
    } phase_e;

    function automatic logic phase_uses_bus(phase_e p);
        return (p != PH_IDLE) && (p != PH_PICK);
    endfunction

    function automatic bus_op_e phase_to_op(phase_e p);
        case (p)
            PH_ADDR:  return OP_START;
            PH_TX:    return OP_SEND;
            PH_RX:    return OP_RECV;
            PH_NACK:  return OP_NACK;
            default:  return OP_STOP;
        endcase
    endfunction

endpackage

// File: rtl/i2cs_phase_ctrl.sv
module i2cs_phase_ctrl
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              buf_we,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              bus_done,
    input  logic              bus_nak,
    input  logic [BYTE_W-1:0] bus_rdata,
    input  logic              bus_err,
    output logic [CMD_W-1:0]  cmd_q,
    output xfer_state_e       xstate_q,
    output logic [BYTE_W-1:0] tx_q,
    output logic [BYTE_W-1:0] rx_q,
    output logic              busy,
    output logic              start_cmd,
    output logic              bus_req,
    output bus_op_e           bus_op,
    output logic [STS_W-1:0]  events
);

    phase_e ph_q;

    logic want_addr, want_tx, want_rx, want_stop;
    logic stray_stop;

    assign want_addr = cmd_q[C_ADDR];
    assign want_tx   = cmd_q[C_TX];
    assign want_rx   = cmd_q[C_RX] | cmd_q[C_RXL];
    assign want_stop = cmd_q[C_STOP];

    assign stray_stop = (ph_q == PH_PICK) && !want_addr && !want_tx && !want_rx
                        && want_stop && (xstate_q != XS_OPEN);

    assign busy      = (ph_q != PH_IDLE);
    assign start_cmd = cmd_we && (ph_q == PH_IDLE);
    assign bus_req   = phase_uses_bus(ph_q);
    assign bus_op    = phase_to_op(ph_q);

    always_comb begin
        events        = '0;
        events[S_ACK] = bus_done && !bus_nak && ((ph_q == PH_ADDR) || (ph_q == PH_TX));
        events[S_NAK] = bus_done &&  bus_nak && ((ph_q == PH_ADDR) || (ph_q == PH_TX));
        events[S_RXD] = bus_done && (ph_q == PH_RX);
        events[S_OK]  = bus_done && (ph_q == PH_STOP);
        events[S_BAD] = stray_stop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            cmd_q    <= '0;
            xstate_q <= XS_IDLE;
            tx_q     <= '0;
            rx_q     <= '0;
        end else begin
            if (buf_we && !busy) begin
                tx_q <= buf_wdata;
            end
            case (ph_q)
                PH_IDLE: begin
                    if (cmd_we) begin
                        cmd_q <= cmd_wdata;
                        ph_q  <= PH_PICK;
                    end
                end
                PH_PICK: begin
                    if (want_addr) begin
                        xstate_q <= (xstate_q == XS_OPEN) ? XS_RSTART : XS_START;
                        ph_q     <= PH_ADDR;
                    end else if (want_tx) begin
                        xstate_q <= XS_TXD;
                        ph_q     <= PH_TX;
                    end else if (want_rx) begin
                        xstate_q <= XS_RXD;
                        ph_q     <= PH_RX;
                    end else if (want_stop) begin
                        if (xstate_q == XS_OPEN) begin
                            xstate_q <= XS_STOP;
                            ph_q     <= PH_STOP;
                        end else begin
                            cmd_q[C_STOP] <= 1'b0;
                            xstate_q      <= XS_IDLE;
                            ph_q          <= PH_IDLE;
                        end
                    end else begin
                        ph_q <= PH_IDLE;
                    end
                end
                PH_ADDR: begin
                    if (bus_done) begin
                        cmd_q[C_ADDR] <= 1'b0;
                        cmd_q[C_TX]   <= 1'b0;
                        if (bus_nak) begin
                            cmd_q[C_RX]   <= 1'b0;
                            cmd_q[C_RXL]  <= 1'b0;
                            cmd_q[C_STOP] <= 1'b0;
                            ph_q          <= PH_IDLE;
                        end else begin
                            xstate_q <= XS_OPEN;
                            ph_q     <= PH_PICK;
                        end
                    end
                end
                PH_TX: begin
                    if (bus_done) begin
                        cmd_q[C_TX] <= 1'b0;
                        if (bus_nak) begin
                            ph_q <= PH_TXEND;
                        end else begin
                            xstate_q <= XS_OPEN;
                            ph_q     <= PH_PICK;
                        end
                    end
                end
                PH_TXEND: begin
                    if (bus_done) begin
                        xstate_q <= XS_OPEN;
                        ph_q     <= PH_PICK;
                    end
                end
                PH_RX: begin
                    if (bus_done) begin
                        rx_q <= bus_err ? {BYTE_W{1'b1}} : bus_rdata;
                        if (cmd_q[C_RXL]) begin
                            ph_q <= PH_NACK;
                        end else begin
                            cmd_q[C_RX] <= 1'b0;
                            xstate_q    <= XS_OPEN;
                            ph_q        <= PH_PICK;
                        end
                    end
                end
                PH_NACK: begin
                    if (bus_done) begin
                        cmd_q[C_RX]  <= 1'b0;
                        cmd_q[C_RXL] <= 1'b0;
                        xstate_q     <= XS_OPEN;
                        ph_q         <= PH_PICK;
                    end
                end
                PH_STOP: begin
                    if (bus_done) begin
                        cmd_q[C_STOP] <= 1'b0;
                        xstate_q      <= XS_IDLE;
                        ph_q          <= PH_IDLE;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2cs_status.sv
module i2cs_status
    import i2cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             w1c_we,
    input  logic [STS_W-1:0] w1c_mask,
    input  logic [STS_W-1:0] events,
    input  logic [STS_W-1:0] irq_en,
    output logic [STS_W-1:0] sts_q,
    output logic             irq
);

    logic [STS_W-1:0] hit;

    for (genvar i = 0; i < STS_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                sts_q[i] <= 1'b0;
            end else if (events[i]) begin
                sts_q[i] <= 1'b1;
            end else if (w1c_we && w1c_mask[i]) begin
                sts_q[i] <= 1'b0;
            end
        end
        assign hit[i] = sts_q[i] & irq_en[i];
    end

    assign irq = |hit;

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2cs_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_we,
    input  logic [CMD_W-1:0]         cmd_wdata,
    input  logic                     buf_we,
    input  logic [BYTE_W-1:0]        buf_wdata,
    input  logic                     sts_w1c_we,
    input  logic [STS_W-1:0]         sts_w1c_mask,
    input  logic [STS_W-1:0]         irq_en,
    output logic [STATE_W+CMD_W-1:0] cmd_reg,
    output logic [2*BYTE_W-1:0]      byte_buf,
    output logic [STS_W-1:0]         sts,
    output logic                     irq,
    output logic                     busy,
    output logic                     bus_req,
    output logic [2:0]               bus_op,
    output logic [BYTE_W-1:0]        bus_wdata,
    input  logic                     bus_done,
    input  logic                     bus_nak,
    input  logic [BYTE_W-1:0]        bus_rdata,
    input  logic                     bus_err
);

    logic [CMD_W-1:0]  cmd_q;
    xfer_state_e       xstate_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;
    logic [STS_W-1:0]  events;
    logic              start_cmd;
    bus_op_e           op_e;

    i2cs_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .buf_we    (buf_we),
        .buf_wdata (buf_wdata),
        .bus_done  (bus_done),
        .bus_nak   (bus_nak),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .cmd_q     (cmd_q),
        .xstate_q  (xstate_q),
        .tx_q      (tx_q),
        .rx_q      (rx_q),
        .busy      (busy),
        .start_cmd (start_cmd),
        .bus_req   (bus_req),
        .bus_op    (op_e),
        .events    (events)
    );

    i2cs_status u_sts (
        .clk      (clk),
        .rst      (rst),
        .clr_all  (start_cmd),
        .w1c_we   (sts_w1c_we),
        .w1c_mask (sts_w1c_mask),
        .events   (events),
        .irq_en   (irq_en),
        .sts_q    (sts),
        .irq      (irq)
    );

    assign cmd_reg   = {xstate_q, cmd_q};
    assign byte_buf  = {rx_q, tx_q};
    assign bus_op    = op_e;
    assign bus_wdata = tx_q;

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic [STATE_W+CMD_W-1:0] cmd_reg,
    input logic [STS_W-1:0]         sts,
    input logic                     busy,
    input logic                     bus_req,
    input logic [2:0]               bus_op,
    input logic [BYTE_W-1:0]        bus_wdata,
    input logic                     bus_done
);

    logic [STATE_W-1:0] st;
    assign st = cmd_reg[STATE_W+CMD_W-1:CMD_W];

    assert_status_cleared_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (sts == '0));

    assert_addr_state_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_op == 3'd0) |-> (st == 4'd1 || st == 4'd2));

    assert_nack_in_rx_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_op == 3'd3) |-> (st == 4'd4));

    assert_bad_stop_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sts[S_BAD]) |-> (st == 4'd0 && !bus_req));

    assert_bits_drained_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cmd_reg[4:0] == 5'd0));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_op) && $stable(bus_wdata)));

    assert_idle_no_req_R12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req);

endmodule

bind i2c_cmd_seq i2cs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_reg   (cmd_reg),
    .sts       (sts),
    .busy      (busy),
    .bus_req   (bus_req),
    .bus_op    (bus_op),
    .bus_wdata (bus_wdata),
    .bus_done  (bus_done)
);

// File: tb/i2c_cmd_seq_tb_top.sv
module i2c_cmd_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic        buf_we = 1'b0;
    logic [7:0]  buf_wdata = '0;
    logic        sts_w1c_we = 1'b0;
    logic [4:0]  sts_w1c_mask = '0;
    logic [4:0]  irq_en = '0;
    logic [19:0] cmd_reg;
    logic [15:0] byte_buf;
    logic [4:0]  sts;
    logic        irq, busy, bus_req;
    logic [2:0]  bus_op;
    logic [7:0]  bus_wdata;
    logic        bus_done = 1'b0;
    logic        bus_nak = 1'b0;
    logic [7:0]  bus_rdata = '0;
    logic        bus_err = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [2:0] op;
        logic [7:0] data;
        logic [3:0] st;
        logic       nak;
        logic [7:0] rd;
        logic       err;
        string      tag;
    } item_t;

    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_cmd_seq dut_i (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .sts_w1c_we(sts_w1c_we),
        .sts_w1c_mask(sts_w1c_mask), .irq_en(irq_en), .cmd_reg(cmd_reg),
        .byte_buf(byte_buf), .sts(sts), .irq(irq), .busy(busy),
        .bus_req(bus_req), .bus_op(bus_op), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_nak(bus_nak), .bus_rdata(bus_rdata),
        .bus_err(bus_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] op, input logic [7:0] data, input logic [3:0] st,
                        input logic nak, input logic [7:0] rd, input logic err, input string tag);
        item_t it;
        it.op = op; it.data = data; it.st = st; it.nak = nak;
        it.rd = rd; it.err = err; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor and bus responder: pops expected operations and answers them
    initial begin
        forever begin
            @(negedge clk);
            bus_done = 1'b0;
            if (!rst && bus_req) begin
                repeat (LAT) @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected bus op", {29'd0, bus_op}, 32'hFF);
                    bus_nak = 1'b0; bus_err = 1'b0;
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk({it.tag, " op"}, {29'd0, bus_op}, {29'd0, it.op});
                    chk({it.tag, " state"}, {28'd0, cmd_reg[19:16]}, {28'd0, it.st});
                    chk("R12 request held", {31'd0, bus_req}, 32'd1);
                    if (it.op == 3'd0 || it.op == 3'd1)
                        chk({it.tag, " byte"}, {24'd0, bus_wdata}, {24'd0, it.data});
                    bus_nak = it.nak; bus_rdata = it.rd; bus_err = it.err;
                end
                bus_done = 1'b1;
            end
        end
    end

    task automatic set_buf(input logic [7:0] b);
        @(negedge clk);
        buf_we = 1'b1; buf_wdata = b;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic do_cmd(input logic [15:0] c, input bit extra);
        int n;
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = c;
        @(negedge clk);
        if (extra) begin
            cmd_wdata = 16'h0010;
            buf_we = 1'b1; buf_wdata = 8'hFF;
            @(negedge clk);
            buf_we = 1'b0;
        end
        cmd_we = 1'b0;
        n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        chk("R10 all expected ops done", exp_q.size(), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset cmd_reg", cmd_reg, 0);
        chk("R1 reset sts", sts, 0);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset busy", busy, 0);
        chk("R12 reset bus_req", bus_req, 0);

        // address phase from idle
        set_buf(8'hA0);
        push(3'd0, 8'hA0, 4'd1, 1'b0, 8'h00, 1'b0, "R3 addr from idle");
        do_cmd(16'h0001, 1'b0);
        chk("R4 ack status", sts, 5'h01);
        chk("R4 state open", cmd_reg[19:16], 4'd8);
        chk("R1 cmd bits low", cmd_reg[15:0], 16'h0000);

        // plain transmit
        set_buf(8'h5A);
        push(3'd1, 8'h5A, 4'd3, 1'b0, 8'h00, 1'b0, "R6 send");
        do_cmd(16'h0002, 1'b0);
        chk("R6 tx ack", sts, 5'h01);
        chk("R6 state open", cmd_reg[19:16], 4'd8);

        // receive then stop in one command
        push(3'd2, 8'h00, 4'd4, 1'b0, 8'h3C, 1'b0, "R7 recv");
        push(3'd4, 8'h00, 4'd5, 1'b0, 8'h00, 1'b0, "R9 stop");
        do_cmd(16'h0014, 1'b0);
        chk("R7 R9 status", sts, 5'h0C);
        chk("R9 state idle", cmd_reg[19:16], 4'd0);
        chk("R7 rx byte", byte_buf[15:8], 8'h3C);
        @(negedge clk);
        sts_w1c_we = 1'b1; sts_w1c_mask = 5'h04;
        @(negedge clk);
        sts_w1c_we = 1'b0;
        chk("R11 partial clear", sts, 5'h08);

        // stray stop
        do_cmd(16'h0010, 1'b0);
        chk("R9 abnormal stop", sts, 5'h10);
        chk("R9 state idle", cmd_reg[19:16], 4'd0);
        irq_en = 5'h0F;
        #1 chk("R11 masked irq", irq, 0);
        @(negedge clk);
        irq_en = 5'h10;
        #1 chk("R11 enabled irq", irq, 1);
        @(negedge clk);
        sts_w1c_we = 1'b1; sts_w1c_mask = 5'h10;
        @(negedge clk);
        sts_w1c_we = 1'b0;
        chk("R11 w1c clears", sts, 5'h00);
        chk("R11 irq drops", irq, 0);
        irq_en = 5'h00;

        // chained command: addr+tx+rxlast+stop, failed receive
        set_buf(8'hA1);
        push(3'd0, 8'hA1, 4'd1, 1'b0, 8'h00, 1'b0, "R4 chained addr");
        push(3'd2, 8'h00, 4'd4, 1'b0, 8'h12, 1'b1, "R4 no send, recv");
        push(3'd3, 8'h00, 4'd4, 1'b0, 8'h00, 1'b0, "R8 nack");
        push(3'd4, 8'h00, 4'd5, 1'b0, 8'h00, 1'b0, "R10 stop last");
        do_cmd(16'h001B, 1'b0);
        chk("R10 chain status", sts, 5'h0D);
        chk("R7 failed recv byte", byte_buf[15:8], 8'hFF);
        chk("R10 chain state", cmd_reg[19:16], 4'd0);

        // address not acknowledged: rest skipped
        set_buf(8'h42);
        push(3'd0, 8'h42, 4'd1, 1'b1, 8'h00, 1'b0, "R5 addr nak");
        do_cmd(16'h0013, 1'b0);
        chk("R5 nak status", sts, 5'h02);
        chk("R5 state kept", cmd_reg[19:16], 4'd1);
        chk("R5 bits cleared", cmd_reg[4:0], 5'd0);
        do_cmd(16'h0010, 1'b0);
        chk("R9 stop after nak abnormal", sts, 5'h10);

        // repeated start, tx nak
        set_buf(8'hA0);
        push(3'd0, 8'hA0, 4'd1, 1'b0, 8'h00, 1'b0, "R3 first addr");
        do_cmd(16'h0001, 1'b0);
        push(3'd0, 8'hA0, 4'd2, 1'b0, 8'h00, 1'b0, "R3 repeated addr");
        do_cmd(16'h0001, 1'b0);
        chk("R3 repeated ack", sts, 5'h01);
        set_buf(8'h77);
        push(3'd1, 8'h77, 4'd3, 1'b1, 8'h00, 1'b0, "R6 send nak");
        push(3'd4, 8'h00, 4'd3, 1'b0, 8'h00, 1'b0, "R6 end transfer");
        do_cmd(16'h0002, 1'b0);
        chk("R6 nak status", sts, 5'h02);
        chk("R6 state back open", cmd_reg[19:16], 4'd8);
        push(3'd4, 8'h00, 4'd5, 1'b0, 8'h00, 1'b0, "R9 normal stop");
        do_cmd(16'h0010, 1'b0);
        chk("R9 normal stop status", sts, 5'h08);

        // writes while busy are ignored
        set_buf(8'hA0);
        push(3'd0, 8'hA0, 4'd1, 1'b0, 8'h00, 1'b0, "R2 addr with busy writes");
        do_cmd(16'h0001, 1'b1);
        chk("R2 no stop ran", cmd_reg[19:16], 4'd8);
        chk("R2 buffer kept", byte_buf[7:0], 8'hA0);
        chk("R2 status", sts, 5'h01);
        push(3'd4, 8'h00, 4'd5, 1'b0, 8'h00, 1'b0, "R9 cleanup stop");
        do_cmd(16'h0010, 1'b0);

        finish_sim();
    end

endmodule